// File: doc/BRIEF.md
# Five-Input Vectored Interrupt Controller

This block sits beside an 8-bit CPU core and picks one of five interrupt request lines to service. One line (the urgent line) can never be masked. Three lines (high, middle and low) have fixed service addresses in the bottom 256-byte page and can be masked. The fifth, external line has no fixed address: when it wins, the block raises a flag telling the core that the requesting device will supply the address, and during the grant it pulses an acknowledge strobe toward that device. The core owns a global enable flag, which it sets and clears with single-cycle pulses. It also writes a three-bit mask through a gated write port.

A small state machine with three states controls the hand-off. In `ST_IDLE` it looks at the eligible lines. When at least one is eligible it takes the transition *capture* to `ST_OFFER` and latches the winner. `ST_OFFER` holds the request and the address steady until the core acknowledges; that transition is *accept* and leads to `ST_GRANT`. `ST_GRANT` lasts exactly one cycle. It pulses the device acknowledge if the external line won, clears the winner's pending latch and clears the global enable. It then takes the transition *release* back to `ST_IDLE`. When nothing is eligible, `ST_IDLE` *waits* in place, and `ST_OFFER` *holds* in place while no acknowledge arrives.

Top module: `vic5_ctrl`

## Requirements
- R1: After reset the global enable is clear, all three mask bits are set (masked), both edge latches are empty, and `cpu_req` and `inta` are low.
- R2: The urgent line `irq_nmi` is served whatever the global enable and the mask bits are, and its service address is 0x0024.
- R3: While offering, the fixed service addresses are 0x003C for `irq_hi`, 0x0034 for `irq_mid` and 0x002C for `irq_lo`, all inside 0x0000–0x00FF. When the external line wins, `ext_vec` is 1 and `svc_addr` is 0x0000.
- R4: Priority from highest to lowest is urgent, high, middle, low, external. Only the highest eligible line is offered.
- R5: A rising edge on `irq_hi` sets a pending latch. The latch stays set after the input falls, until the high line is granted.
- R6: A cycle with `msk_wr` and `hi_clr` both high empties the high-line latch, whatever `msk_wen` is.
- R7: `irq_mid`, `irq_lo` and `irq_ext` are level sensitive. A level that goes away before it becomes eligible leaves no request behind.
- R8: `msk_bits` (bit 2 high, bit 1 middle, bit 0 low; 1 = masked) are loaded only in a cycle where `msk_wr` and `msk_wen` are both high. A masked line is never offered.
- R9: The maskable lines are eligible only while the global enable is set. `ien_set` sets the enable and `ien_clr` clears it, and clear wins if both are high. The external line ignores the mask bits.
- R10: Granting any line clears the global enable, and this takes priority over a same-cycle `ien_set`.
- R11: `cpu_req` stays high with `svc_addr` and `ext_vec` unchanged until `cpu_ack` is sampled high. The next cycle is the grant cycle: `cpu_req` is low, and `inta` is high for exactly that one cycle if and only if the external line was offered.
- R12: The urgent line is latched on its rising edge. The latch holds until the line is granted, so a single pulse is served once and a line held high is not served again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_nmi | input | 1 | Urgent request, edge latched, never masked |
| irq_hi | input | 1 | High-priority maskable request, edge latched |
| irq_mid | input | 1 | Middle maskable request, level |
| irq_lo | input | 1 | Low maskable request, level |
| irq_ext | input | 1 | External-vector request, level |
| ien_set | input | 1 | Pulse that sets the global enable |
| ien_clr | input | 1 | Pulse that clears the global enable |
| msk_wr | input | 1 | Mask port write strobe |
| msk_wen | input | 1 | Mask load enable for this write |
| msk_bits | input | 3 | New mask bits {high, middle, low} |
| hi_clr | input | 1 | Empties the high-line latch on a mask port write |
| cpu_ack | input | 1 | Core accepts the offered interrupt |
| cpu_req | output | 1 | Interrupt offered to the core |
| svc_addr | output | 16 | Service address of the offered line |
| ext_vec | output | 1 | Offered line takes its address from the device |
| inta | output | 1 | Device acknowledge strobe in the grant cycle |

## Verification
The bench aims at cases where several lines arrive in the same cycle. A wrong priority chain would offer the middle or external line ahead of the urgent one. It pulses the high line while it is disabled and later enables it: a level-sensitive design would lose that request, and a design without the clear path would still serve a latch that software had emptied. It holds the urgent line high across its grant, which catches a level-sensitive latch that serves it again and again. It also checks that the enable is gone straight after a grant and that a gated mask write without its load enable changes nothing. A design that forgot either would offer the next line without software re-enabling it.

// File: rtl/vic5_pkg.sv
package vic5_pkg;

    localparam int SRC_COUNT = 5;
    localparam int MASK_W    = 3;
    localparam int EDGE_W    = 2;

    typedef enum logic [2:0] {
        SRC_NMI = 3'd0,
        SRC_HI  = 3'd1,
        SRC_MID = 3'd2,
        SRC_LO  = 3'd3,
        SRC_EXT = 3'd4
    } vic_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_GRANT = 2'd2
    } vic_state_e;

endpackage

// File: rtl/vic5_edge_latch.sv
module vic5_edge_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_q;
        logic pend_q;
        logic rise;

        assign rise = lvl[g] & ~prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= lvl[g];
                // a fresh edge beats a clear in the same cycle
                pend_q <= rise | (pend_q & ~clr[g]);
            end
        end

        assign pend[g] = pend_q;
    end

endmodule

// File: rtl/vic5_prio.sv
module vic5_prio #(
    parameter int N     = 5,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);

    // index 0 is the most urgent
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic5_ctrl.sv
module vic5_ctrl
    import vic5_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0024,
    parameter logic [ADDR_W-1:0] HI_VEC  = 16'h003C,
    parameter logic [ADDR_W-1:0] MID_VEC = 16'h0034,
    parameter logic [ADDR_W-1:0] LO_VEC  = 16'h002C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_nmi,
    input  logic              irq_hi,
    input  logic              irq_mid,
    input  logic              irq_lo,
    input  logic              irq_ext,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              msk_wr,
    input  logic              msk_wen,
    input  logic [2:0]        msk_bits,
    input  logic              hi_clr,
    input  logic              cpu_ack,
    output logic              cpu_req,
    output logic [ADDR_W-1:0] svc_addr,
    output logic              ext_vec,
    output logic              inta
);

    localparam int IDX_W   = $clog2(SRC_COUNT);
    localparam int M_HI    = MASK_W - 1;
    localparam int M_MID   = MASK_W - 2;
    localparam int M_LO    = MASK_W - 3;
    localparam int E_NMI   = 0;
    localparam int E_HI    = 1;

    vic_state_e        state_q, state_n;
    vic_src_e          sel_q;
    logic              ien_q;
    logic [MASK_W-1:0] mask_q;
    logic [EDGE_W-1:0] edge_pend, edge_clr;
    logic [SRC_COUNT-1:0] elig;
    logic              win_vld;
    logic [IDX_W-1:0]  win_idx;
    logic              granting;
    logic [ADDR_W-1:0] vec_sel;

    assign granting = (state_q == ST_GRANT);

    // edge-latched lines: urgent and high
    assign edge_clr[E_NMI] = granting && (sel_q == SRC_NMI);
    assign edge_clr[E_HI]  = (granting && (sel_q == SRC_HI)) || (msk_wr && hi_clr);

    vic5_edge_latch #(.N(EDGE_W)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({irq_hi, irq_nmi}),
        .clr  (edge_clr),
        .pend (edge_pend)
    );

    // eligibility per source, indexed by priority
    always_comb begin
        elig          = '0;
        elig[SRC_NMI] = edge_pend[E_NMI];
        elig[SRC_HI]  = edge_pend[E_HI] & ~mask_q[M_HI]  & ien_q;
        elig[SRC_MID] = irq_mid         & ~mask_q[M_MID] & ien_q;
        elig[SRC_LO]  = irq_lo          & ~mask_q[M_LO]  & ien_q;
        elig[SRC_EXT] = irq_ext         & ien_q;
    end

    vic5_prio #(.N(SRC_COUNT), .IDX_W(IDX_W)) u_prio (
        .req(elig),
        .vld(win_vld),
        .idx(win_idx)
    );

    // global enable and mask register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            mask_q <= '1;
        end else begin
            if (granting || ien_clr) begin
                ien_q <= 1'b0;
            end else if (ien_set) begin
                ien_q <= 1'b1;
            end
            if (msk_wr && msk_wen) begin
                mask_q <= msk_bits;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= SRC_NMI;
        end else begin
            state_q <= state_n;
            if (state_q == ST_IDLE && win_vld) begin
                sel_q <= vic_src_e'(win_idx);
            end
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (win_vld) state_n = ST_OFFER;
            ST_OFFER: if (cpu_ack) state_n = ST_GRANT;
            ST_GRANT: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (sel_q)
            SRC_NMI: vec_sel = NMI_VEC;
            SRC_HI:  vec_sel = HI_VEC;
            SRC_MID: vec_sel = MID_VEC;
            SRC_LO:  vec_sel = LO_VEC;
            default: vec_sel = '0;
        endcase
    end

    // outputs
    always_comb begin
        cpu_req  = 1'b0;
        ext_vec  = 1'b0;
        inta     = 1'b0;
        svc_addr = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OFFER: begin
                cpu_req = 1'b1;
                if (sel_q == SRC_EXT) begin
                    ext_vec = 1'b1;
                end else begin
                    svc_addr = vec_sel;
                end
            end
            ST_GRANT: inta = (sel_q == SRC_EXT);
            default: ;
        endcase
    end

endmodule

// File: rtl/vic5_checker.sv
module vic5_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ack,
    input logic [ADDR_W-1:0] svc_addr,
    input logic              ext_vec,
    input logic              inta,
    input logic              msk_wr,
    input logic              msk_wen,
    input logic [2:0]        mask_q,
    input logic              ien_q
);

    p_accept_drops_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack) |=> (!cpu_req && (inta == $past(ext_vec))))
        else $error("p_accept_drops_req_r11");

    p_offer_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ack) |=> (cpu_req && $stable(svc_addr) && $stable(ext_vec)))
        else $error("p_offer_steady_r11");

    p_inta_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> !inta)
        else $error("p_inta_single_r11");

    p_inta_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inta |-> $past(cpu_req && cpu_ack && ext_vec))
        else $error("p_inta_after_accept_r11");

    p_low_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !ext_vec) |-> (svc_addr[ADDR_W-1:8] == '0 && svc_addr != '0))
        else $error("p_low_page_r3");

    p_ext_no_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_vec |-> (cpu_req && svc_addr == '0))
        else $error("p_ext_no_addr_r3");

    p_accept_clears_ien_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack) |=> ##1 !ien_q)
        else $error("p_accept_clears_ien_r10");

    p_mask_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_wr && !msk_wen) |=> $stable(mask_q))
        else $error("p_mask_gated_r8");

endmodule

bind vic5_ctrl vic5_checker #(.ADDR_W(ADDR_W)) u_vic5_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (cpu_req),
    .cpu_ack (cpu_ack),
    .svc_addr(svc_addr),
    .ext_vec (ext_vec),
    .inta    (inta),
    .msk_wr  (msk_wr),
    .msk_wen (msk_wen),
    .mask_q  (mask_q),
    .ien_q   (ien_q)
);

// File: tb/test_vic5_ctrl.sv
module test_vic5_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_nmi = 0, irq_hi = 0, irq_mid = 0, irq_lo = 0, irq_ext = 0;
    logic        ien_set = 0, ien_clr = 0, msk_wr = 0, msk_wen = 0, hi_clr = 0, cpu_ack = 0;
    logic [2:0]  msk_bits = 3'b000;
    logic        cpu_req, ext_vec, inta;
    logic [15:0] svc_addr;

    int n_run  = 0;
    int n_fail = 0;
    logic model_on = 1'b0;

    always #5 clk = ~clk;

    vic5_ctrl i_vic5_ctrl (
        .clk(clk), .rst_n(rst_n),
        .irq_nmi(irq_nmi), .irq_hi(irq_hi), .irq_mid(irq_mid), .irq_lo(irq_lo), .irq_ext(irq_ext),
        .ien_set(ien_set), .ien_clr(ien_clr),
        .msk_wr(msk_wr), .msk_wen(msk_wen), .msk_bits(msk_bits), .hi_clr(hi_clr),
        .cpu_ack(cpu_ack),
        .cpu_req(cpu_req), .svc_addr(svc_addr), .ext_vec(ext_vec), .inta(inta)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model built from the requirements ----------------
    logic [1:0] m_st;     // 0 idle, 1 offer, 2 grant
    logic [2:0] m_sel;    // 0 urgent .. 4 external
    logic       m_ien;
    logic [2:0] m_mask;
    logic       m_pn, m_ph, m_prev_n, m_prev_h;
    logic [4:0] m_el;

    always_comb begin
        m_el[0] = m_pn;
        m_el[1] = m_ph & ~m_mask[2] & m_ien;
        m_el[2] = irq_mid & ~m_mask[1] & m_ien;
        m_el[3] = irq_lo & ~m_mask[0] & m_ien;
        m_el[4] = irq_ext & m_ien;
    end

    function automatic logic [2:0] first_of(input logic [4:0] e);
        for (int i = 0; i < 5; i++) if (e[i]) return 3'(i);
        return 3'd0;
    endfunction

    function automatic logic [15:0] addr_of(input logic [2:0] s);
        case (s)
            3'd0: return 16'h0024;
            3'd1: return 16'h003C;
            3'd2: return 16'h0034;
            3'd3: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_sel <= 0; m_ien <= 0; m_mask <= 3'b111;
            m_pn <= 0; m_ph <= 0; m_prev_n <= 0; m_prev_h <= 0;
        end else begin
            case (m_st)
                2'd0: if (|m_el) begin m_st <= 2'd1; m_sel <= first_of(m_el); end
                2'd1: if (cpu_ack) m_st <= 2'd2;
                default: m_st <= 2'd0;
            endcase
            m_ien <= (m_st == 2'd2) ? 1'b0 : (ien_clr ? 1'b0 : (ien_set ? 1'b1 : m_ien));
            if (msk_wr && msk_wen) m_mask <= msk_bits;
            m_pn <= (irq_nmi & ~m_prev_n) | (m_pn & ~(m_st == 2'd2 && m_sel == 3'd0));
            m_ph <= (irq_hi & ~m_prev_h) |
                    (m_ph & ~((m_st == 2'd2 && m_sel == 3'd1) || (msk_wr && hi_clr)));
            m_prev_n <= irq_nmi;
            m_prev_h <= irq_hi;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            chk("R4 model cpu_req", 32'(cpu_req), 32'(m_st == 2'd1));
            chk("R3 model ext_vec", 32'(ext_vec), 32'(m_st == 2'd1 && m_sel == 3'd4));
            chk("R3 model svc_addr", 32'(svc_addr),
                32'((m_st == 2'd1) ? addr_of(m_sel) : 16'h0000));
            chk("R11 model inta", 32'(inta), 32'(m_st == 2'd2 && m_sel == 3'd4));
        end
    end

    // ---------------- directed helpers ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_ien();
        ien_set = 1; tick(); ien_set = 0; tick();
    endtask

    task automatic accept(input logic exp_inta);
        cpu_ack = 1; tick(); cpu_ack = 0;
        chk("R11 inta in grant", 32'(inta), 32'(exp_inta));
        chk("R11 req low in grant", 32'(cpu_req), 32'd0);
        tick();
    endtask

    task automatic run_all();
        repeat (3) tick();
        rst_n = 1; model_on = 1;
        tick();
        chk("R1 req after reset", 32'(cpu_req), 32'd0);
        chk("R1 inta after reset", 32'(inta), 32'd0);

        irq_ext = 1; irq_lo = 1; tick(); tick();
        chk("R1 enable clear: no request", 32'(cpu_req), 32'd0);

        pulse_ien();
        chk("R9 ext offered once enabled", 32'(cpu_req), 32'd1);
        chk("R3 ext flag", 32'(ext_vec), 32'd1);
        chk("R1 masks set: lo not chosen, R3 addr zero", 32'(svc_addr), 32'd0);
        tick(); tick();
        chk("R11 offer held without ack", 32'(ext_vec), 32'd1);
        accept(1'b1);
        chk("R11 inta lasts one cycle", 32'(inta), 32'd0);
        tick(); tick();
        chk("R10 enable cleared by grant", 32'(cpu_req), 32'd0);

        msk_wr = 1; msk_wen = 0; msk_bits = 3'b000; tick(); msk_wr = 0;
        pulse_ien();
        chk("R8 ungated write ignored", 32'(ext_vec), 32'd1);
        accept(1'b1);

        msk_wr = 1; msk_wen = 1; msk_bits = 3'b000; tick(); msk_wr = 0; msk_wen = 0;
        pulse_ien();
        chk("R8 lo unmasked, R3 lo addr", 32'(svc_addr), 32'h002C);
        chk("R4 lo above ext", 32'(ext_vec), 32'd0);
        accept(1'b0);
        irq_ext = 0; irq_lo = 0;

        irq_mid = 1; tick(); irq_mid = 0; tick();
        pulse_ien();
        chk("R7 vanished level leaves nothing", 32'(cpu_req), 32'd0);
        ien_clr = 1; tick(); ien_clr = 0; tick();

        irq_hi = 1; tick(); irq_hi = 0; repeat (4) tick();
        pulse_ien();
        chk("R5 edge held until enabled", 32'(svc_addr), 32'h003C);
        accept(1'b0);

        irq_hi = 1; tick(); irq_hi = 0; msk_wr = 1; hi_clr = 1; tick(); msk_wr = 0; hi_clr = 0;
        pulse_ien();
        chk("R6 latch clear drops request", 32'(cpu_req), 32'd0);

        msk_wr = 1; msk_wen = 1; msk_bits = 3'b111; irq_ext = 1; tick();
        msk_wr = 0; msk_wen = 0; tick();
        chk("R9 ext ignores mask bits", 32'(ext_vec), 32'd1);
        accept(1'b1);
        irq_ext = 0;

        irq_nmi = 1; tick(); tick();
        chk("R2 urgent despite enable and masks", 32'(svc_addr), 32'h0024);
        irq_nmi = 0; tick(); tick();
        chk("R12 urgent held until ack", 32'(svc_addr), 32'h0024);
        accept(1'b0);
        tick(); tick();
        chk("R12 urgent latch empty after grant", 32'(cpu_req), 32'd0);

        irq_hi = 1; msk_wr = 1; msk_wen = 1; msk_bits = 3'b000; tick();
        irq_hi = 0; msk_wr = 0; msk_wen = 0; tick();
        irq_mid = 1; irq_lo = 1; irq_ext = 1; irq_nmi = 1; ien_set = 1; tick(); ien_set = 0; tick();
        chk("R4 urgent first", 32'(svc_addr), 32'h0024);
        accept(1'b0);
        pulse_ien();
        chk("R4 high second", 32'(svc_addr), 32'h003C);
        accept(1'b0);
        pulse_ien();
        chk("R4 middle third, R3 addr", 32'(svc_addr), 32'h0034);
        accept(1'b0);
        irq_mid = 0;
        pulse_ien();
        chk("R4 low fourth", 32'(svc_addr), 32'h002C);
        accept(1'b0);
        irq_lo = 0;
        pulse_ien();
        chk("R4 external last, R12 held urgent not repeated", 32'(ext_vec), 32'd1);
        accept(1'b1);
        irq_ext = 0; irq_nmi = 0;

        void'($urandom(32'd20240611));
        for (int k = 0; k < 3000; k++) begin
            irq_nmi  = ($urandom_range(15) == 0) ? ~irq_nmi : irq_nmi;
            irq_hi   = ($urandom_range(3) == 0);
            irq_mid  = ($urandom_range(2) == 0);
            irq_lo   = ($urandom_range(2) == 0);
            irq_ext  = ($urandom_range(2) == 0);
            ien_set  = ($urandom_range(5) == 0);
            ien_clr  = ($urandom_range(11) == 0);
            msk_wr   = ($urandom_range(9) == 0);
            msk_wen  = 1'($urandom_range(1));
            msk_bits = 3'($urandom_range(7));
            hi_clr   = ($urandom_range(3) == 0);
            cpu_ack  = ($urandom_range(2) == 0);
            tick();
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                n_fail++;
                $display("FAIL R11 watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule